// File: doc/BRIEF.md
# SD Host Block Gap Controller

This block is the pause-and-resume logic that an SD/SDIO host controller uses during multi-block data transfers. Software owns a small 8-bit control register, reached through a plain write-enable/read-data register port, that requests a pause at the next block boundary, restarts a paused transfer, picks how an incoming read is held while paused, and enables interrupt sampling at the pause point.

The transfer engine reports when it starts a transfer, its direction, and each completed block, including whether that block was the last one. From these reports the block decides whether the transfer continues across the boundary or halts there. While a read is halted, the block holds the card's data either by driving the read-wait signal on the DAT[2] line or by turning off the card clock enable. It gives a one-cycle event when a pause actually begins. It also gives separate activity flags for reading and writing, and an enable that tells the interrupt logic when the card's interrupt may be sampled.

The restart bit clears itself. It drops when the matching activity flag rises, so software never has to write it back to zero.

Top module: `sd_gap_ctrl`

## Requirements
- R1: After reset the register reads 0x00. A write stores bit 0 (pause request), bit 2 (read-wait select) and bit 3 (gap interrupt enable). Bits 7:4 always read as 0.
- R2: When the pause request is 1 and a block boundary that is not the last block arrives, the transfer halts at that gap. On the cycle after the boundary, `gap_event` is 1 for exactly one cycle, and `dat_line_active` and `wr_xfer_active` are both 0 while halted.
- R3: When the pause request is 0, a non-last block boundary leaves the activity flag of the running transfer at 1, and `gap_event` stays 0.
- R4: A write of 1 to the restart bit (bit 1) has no effect while the stored pause request is 1. In that case bit 1 reads back as 0.
- R5: Writing 1 to the restart bit while the pause request is 0 makes bit 1 read as 1. A halted transfer then resumes: its activity flag rises on the next cycle, and bit 1 reads 0 from that same cycle on.
- R6: While a read is halted and read-wait is selected (bit 2 = 1), `read_wait_drive` is 1 and `card_clk_en` stays 1.
- R7: While a read is halted and read-wait is not selected (bit 2 = 0), `card_clk_en` is 0 and `read_wait_drive` is 0.
- R8: `card_clk_en` returns to 1 and `read_wait_drive` returns to 0 in the same cycle the restart bit is seen as 1 by a halted transfer.
- R9: A pause request present at the last block's boundary has no effect. The transfer ends with both activity flags at 0 and no `gap_event`.
- R10: `irq_sample_en` is 1 whenever `bus_4bit` is 0. In 4-bit mode it is 1 when no transfer is in progress, 0 while a transfer is running, and equal to bit 3 while a transfer is halted at a gap.
- R11: While a write transfer is halted, `card_clk_en` stays 1 and `read_wait_drive` stays 0. On resume, `wr_xfer_active` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register read data |
| xfer_start | input | 1 | Pulse starting a multi-block transfer |
| xfer_read | input | 1 | Direction of the starting transfer (1 = read) |
| blk_done | input | 1 | Pulse at each block boundary |
| blk_last | input | 1 | Qualifies `blk_done`: the block just finished is the last one |
| bus_4bit | input | 1 | Data bus is in 4-bit mode |
| dat_line_active | output | 1 | A read transfer is moving data |
| wr_xfer_active | output | 1 | A write transfer is moving data |
| gap_event | output | 1 | One-cycle pulse when a halt at a gap begins |
| read_wait_drive | output | 1 | Drive the read-wait signal on DAT[2] |
| card_clk_en | output | 1 | Card clock enable |
| irq_sample_en | output | 1 | Card interrupt may be sampled |

## Verification
On every cycle, the assertions check the following:
- the reserved bits read as zero;
- the restart bit never appears while the pause request was stored;
- the restart bit is already clear whenever an activity flag rises;
- the gap event is a single-cycle pulse and coincides with both flags low;
- read-wait driving and clock stopping are never active together;
- a last-block boundary never leads to a gap event.

Other behaviours need a full scenario and are shown only by the bench's directed sequences:
- the choice between the two read-holding methods;
- the release in the exact cycle the restart is accepted;
- a write transfer resuming;
- the interrupt sampling window in each bus mode.

// File: rtl/sd_gap_pkg.sv
package sd_gap_pkg;
    localparam int REG_W    = 8;
    localparam int BIT_STOP = 0;
    localparam int BIT_CONT = 1;
    localparam int BIT_RWT  = 2;
    localparam int BIT_IRQ  = 3;
    localparam int RSV_LSB  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2
    } xfer_st_e;

    typedef struct packed {
        logic stop;
        logic cont;
        logic rwait;
        logic irq_en;
    } ctl_s;

    typedef struct packed {
        xfer_st_e st;
        logic     rd;
        logic     gap;
    } fsm_s;
endpackage

// File: rtl/sd_gap_reg.sv
module sd_gap_reg
    import sd_gap_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          cont_clr,
    output ctl_s          ctl,
    output logic [DW-1:0] rd_data
);
    ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.stop   = wr_data[BIT_STOP];
            ctl_d.rwait  = wr_data[BIT_RWT];
            ctl_d.irq_en = wr_data[BIT_IRQ];
            // restart bit: write-one-to-set, blocked while pause is stored
            if (wr_data[BIT_CONT] && !ctl_q.stop)
                ctl_d.cont = 1'b1;
        end
        // clearing on activity rise takes priority
        if (cont_clr)
            ctl_d.cont = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rd_data           = '0;
        rd_data[BIT_STOP] = ctl_q.stop;
        rd_data[BIT_CONT] = ctl_q.cont;
        rd_data[BIT_RWT]  = ctl_q.rwait;
        rd_data[BIT_IRQ]  = ctl_q.irq_en;
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/sd_gap_fsm.sv
module sd_gap_fsm
    import sd_gap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     xfer_start,
    input  logic     xfer_read,
    input  logic     blk_done,
    input  logic     blk_last,
    input  ctl_s     ctl,
    output xfer_st_e st,
    output logic     is_read,
    output logic     gap_pulse,
    output logic     act_rise
);
    fsm_s f_d, f_q;

    always_comb begin
        f_d     = f_q;
        f_d.gap = 1'b0;
        unique case (f_q.st)
            ST_IDLE: begin
                if (xfer_start) begin
                    f_d.st = ST_RUN;
                    f_d.rd = xfer_read;
                end
            end
            ST_RUN: begin
                if (blk_done) begin
                    if (blk_last) begin
                        f_d.st = ST_IDLE;
                    end else if (ctl.stop) begin
                        f_d.st  = ST_PAUSE;
                        f_d.gap = 1'b1;
                    end
                end
            end
            ST_PAUSE: begin
                if (ctl.cont)
                    f_d.st = ST_RUN;
            end
            default: f_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: ST_IDLE, rd: 1'b0, gap: 1'b0};
        else        f_q <= f_d;
    end

    assign st        = f_q.st;
    assign is_read   = f_q.rd;
    assign gap_pulse = f_q.gap;
    assign act_rise  = (f_d.st == ST_RUN) && (f_q.st != ST_RUN);
endmodule

// File: rtl/sd_gap_hold.sv
module sd_gap_hold
    import sd_gap_pkg::*;
(
    input  xfer_st_e st,
    input  logic     is_read,
    input  ctl_s     ctl,
    input  logic     bus_4bit,
    output logic     dat_active,
    output logic     wr_active,
    output logic     rw_drive,
    output logic     clk_en,
    output logic     irq_en_out
);
    logic held_rd;

    always_comb begin
        // a paused read stays held until the restart is seen
        held_rd    = (st == ST_PAUSE) && is_read && !ctl.cont;
        dat_active = (st == ST_RUN) && is_read;
        wr_active  = (st == ST_RUN) && !is_read;
        rw_drive   = held_rd && ctl.rwait;
        clk_en     = !(held_rd && !ctl.rwait);
        if (!bus_4bit)
            irq_en_out = 1'b1;
        else
            unique case (st)
                ST_IDLE:  irq_en_out = 1'b1;
                ST_PAUSE: irq_en_out = ctl.irq_en;
                default:  irq_en_out = 1'b0;
            endcase
    end
endmodule

// File: rtl/sd_gap_ctrl.sv
module sd_gap_ctrl
    import sd_gap_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [DW-1:0] reg_wr_data,
    output logic [DW-1:0] reg_rd_data,
    input  logic          xfer_start,
    input  logic          xfer_read,
    input  logic          blk_done,
    input  logic          blk_last,
    input  logic          bus_4bit,
    output logic          dat_line_active,
    output logic          wr_xfer_active,
    output logic          gap_event,
    output logic          read_wait_drive,
    output logic          card_clk_en,
    output logic          irq_sample_en
);
    ctl_s     ctl;
    xfer_st_e st;
    logic     is_read;
    logic     act_rise;

    sd_gap_reg #(.DW(DW)) i_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .cont_clr (act_rise),
        .ctl      (ctl),
        .rd_data  (reg_rd_data)
    );

    sd_gap_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .xfer_read  (xfer_read),
        .blk_done   (blk_done),
        .blk_last   (blk_last),
        .ctl        (ctl),
        .st         (st),
        .is_read    (is_read),
        .gap_pulse  (gap_event),
        .act_rise   (act_rise)
    );

    sd_gap_hold i_hold (
        .st         (st),
        .is_read    (is_read),
        .ctl        (ctl),
        .bus_4bit   (bus_4bit),
        .dat_active (dat_line_active),
        .wr_active  (wr_xfer_active),
        .rw_drive   (read_wait_drive),
        .clk_en     (card_clk_en),
        .irq_en_out (irq_sample_en)
    );
endmodule

// File: rtl/sd_gap_ctrl_chk.sv
module sd_gap_ctrl_chk
    import sd_gap_pkg::*;
#(
    parameter int DW = REG_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] reg_rd_data,
    input logic          blk_done,
    input logic          blk_last,
    input logic          dat_line_active,
    input logic          wr_xfer_active,
    input logic          gap_event,
    input logic          read_wait_drive,
    input logic          card_clk_en
);
    assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[DW-1:RSV_LSB] == '0);

    assert_gap_flags_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gap_event |-> (!dat_line_active && !wr_xfer_active));

    assert_gap_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gap_event |=> !gap_event);

    assert_cont_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rd_data[BIT_CONT]) |-> !$past(reg_rd_data[BIT_STOP]));

    assert_cont_autoclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dat_line_active) || $rose(wr_xfer_active)) |-> !reg_rd_data[BIT_CONT]);

    assert_hold_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(read_wait_drive && !card_clk_en));

    assert_rwait_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        read_wait_drive |-> reg_rd_data[BIT_RWT]);

    assert_last_no_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && blk_last && (dat_line_active || wr_xfer_active))
        |=> (!gap_event && !dat_line_active && !wr_xfer_active));
endmodule

bind sd_gap_ctrl sd_gap_ctrl_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_sd_gap_ctrl.sv
module test_sd_gap_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = '0;
    logic [7:0] reg_rd_data;
    logic       xfer_start = 1'b0, xfer_read = 1'b0;
    logic       blk_done = 1'b0, blk_last = 1'b0, bus_4bit = 1'b0;
    logic       dat_line_active, wr_xfer_active, gap_event;
    logic       read_wait_drive, card_clk_en, irq_sample_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    sd_gap_ctrl i_sd_gap_ctrl (.*);

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr_en = 1'b1; reg_wr_data = d;
        step();
        reg_wr_en = 1'b0;
    endtask

    task automatic start(input logic rd);
        xfer_start = 1'b1; xfer_read = rd;
        step();
        xfer_start = 1'b0;
    endtask

    task automatic blk(input logic last);
        blk_done = 1'b1; blk_last = last;
        step();
        blk_done = 1'b0; blk_last = 1'b0;
    endtask

    task automatic t_reset_regs();
        chk("R1 reset reg", reg_rd_data, 8'h00);
        chk("R1 reset clk_en", card_clk_en, 1);
        chk("R1 reset flags", {dat_line_active, wr_xfer_active, gap_event, read_wait_drive}, 0);
        wr(8'hFD);
        chk("R1 rsv zero", reg_rd_data, 8'h0D);
        wr(8'h00);
        chk("R1 clear", reg_rd_data, 8'h00);
    endtask

    task automatic t_no_stop();
        start(1'b1);
        chk("R3 read active", dat_line_active, 1);
        blk(1'b0);
        chk("R3 still active", dat_line_active, 1);
        chk("R3 no gap", gap_event, 0);
        blk(1'b1);
        chk("R3 done", dat_line_active, 0);
    endtask

    task automatic t_read_wait();
        wr(8'h05);
        start(1'b1);
        blk(1'b0);
        chk("R2 gap pulse", gap_event, 1);
        chk("R2 flag low", dat_line_active, 0);
        chk("R6 rw drive", read_wait_drive, 1);
        chk("R6 clk on", card_clk_en, 1);
        step();
        chk("R2 pulse ends", gap_event, 0);
        wr(8'h07);
        chk("r4_ cont ignored", reg_rd_data[1], 0);
        chk("R4 still paused", dat_line_active, 0);
        wr(8'h04);
        chk("R6 held after stop clr", read_wait_drive, 1);
        wr(8'h06);
        chk("R5 cont set", reg_rd_data[1], 1);
        chk("R8 rw released", read_wait_drive, 0);
        step();
        chk("R5 resumed", dat_line_active, 1);
        chk("R5 cont self clear", reg_rd_data[1], 0);
        blk(1'b1);
    endtask

    task automatic t_clk_stop();
        wr(8'h01);
        start(1'b1);
        blk(1'b0);
        chk("R7 clk off", card_clk_en, 0);
        chk("R7 no rw", read_wait_drive, 0);
        wr(8'h00);
        chk("R7 clk still off", card_clk_en, 0);
        wr(8'h02);
        chk("R8 clk restored", card_clk_en, 1);
        step();
        chk("R5 read resumed", dat_line_active, 1);
        blk(1'b1);
    endtask

    task automatic t_write_pause();
        wr(8'h01);
        start(1'b0);
        chk("R11 wr active", wr_xfer_active, 1);
        blk(1'b0);
        chk("R11 wr paused", wr_xfer_active, 0);
        chk("R11 clk on", card_clk_en, 1);
        chk("R11 no rw", read_wait_drive, 0);
        wr(8'h00);
        wr(8'h02);
        step();
        chk("R11 wr resumed", wr_xfer_active, 1);
        chk("R5 wr cont clear", reg_rd_data[1], 0);
        blk(1'b1);
    endtask

    task automatic t_last_block();
        wr(8'h00);
        start(1'b0);
        wr(8'h01);
        blk(1'b1);
        chk("R9 no gap", gap_event, 0);
        chk("R9 ended", {dat_line_active, wr_xfer_active}, 0);
        step();
        chk("R9 stays idle", {dat_line_active, wr_xfer_active, gap_event}, 0);
    endtask

    task automatic t_irq();
        bus_4bit = 1'b0;
        wr(8'h01);
        start(1'b0);
        chk("R10 1bit always", irq_sample_en, 1);
        bus_4bit = 1'b1;
        #1;
        chk("R10 4bit running", irq_sample_en, 0);
        blk(1'b0);
        chk("R10 paused en0", irq_sample_en, 0);
        wr(8'h08);
        chk("R10 paused en1", irq_sample_en, 1);
        wr(8'h0A);
        step();
        chk("R10 running again", irq_sample_en, 0);
        blk(1'b1);
        chk("R10 idle", irq_sample_en, 1);
        bus_4bit = 1'b0;
        wr(8'h00);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset_regs();
        t_no_stop();
        t_read_wait();
        t_clk_stop();
        t_write_pause();
        t_last_block();
        t_irq();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule